// File: doc/BRIEF.md
# Neural Core Phase Sequencer

This block is the control state machine of one analog neural core. It runs on the clock of the on-chip routing fabric and steps the core through one pass over an input vector. After a start request it accepts 8-bit input words from the router into a local input buffer and presents them to the crossbar drivers. It then holds the crossbar in evaluation for a fixed number of cycles and reads one 3-bit quantized neuron result per cycle into an output buffer. Finally it streams those results back to the router under a valid/ready handshake.

In training mode the same pass continues after the output buffer has drained. The sequencer first enables the error back-propagation circuits for a fixed dwell and then the weight-programming circuits for a fixed dwell, and only then returns to idle. The analog circuits are outside the block. They appear only as phase-enable levels, a neuron select and a quantized code input.

Dwell times are parameters in cycles. The defaults are 4 cycles for a recognition evaluation, 54 for a training forward evaluation, 160 for back-propagation and 200 for weight update. The buffers hold up to 400 inputs and 100 neuron results.

Top module: `nc_phase_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no start, `busy_o`, `rx_ready_o`, `xbar_eval_o`, `tx_valid_o`, `bwd_en_o` and `upd_en_o` are all low.
- R2: A `start_i` pulse seen in idle makes `busy_o` and `rx_ready_o` high from the next cycle. `train_i`, `n_in_i` and `n_out_i` are captured at that edge.
- R3: During loading, every cycle with `rx_valid_i` high stores `rx_data_i` at the next input buffer address, starting at 0. `drv_word_o` returns the word at `drv_addr_i`.
- R4: Loading ends on the beat that completes the captured input count, and `xbar_eval_o` rises in the following cycle. An input count of 0 or above 400 is treated as 400, and an output count of 0 or above 100 is treated as 100.
- R5: In recognition mode `xbar_eval_o` stays high for exactly 4 cycles.
- R6: In training mode `xbar_eval_o` stays high for exactly 54 cycles.
- R7: After evaluation, one capture cycle follows for each neuron k = 0 .. n_out-1, in that order. `adc_sel_o` equals k, and `adc_code_i` is stored as result k.
- R8: While results are sent, `tx_valid_o` is high and `tx_data_o` carries result k in bits [2:0] with bits [7:3] zero. k advances only on cycles with `tx_ready_i` high, and data is held stable while the router stalls.
- R9: In recognition mode the core returns to idle in the cycle after the last result is accepted. `bwd_en_o` and `upd_en_o` never rise.
- R10: In training mode `bwd_en_o` is high for exactly 160 cycles after the last result is accepted, then `upd_en_o` is high for exactly 200 cycles, then the core is idle.
- R11: `busy_o` is high from the first loading cycle through the last cycle of the final phase. A `start_i` pulse while busy has no effect on the sequence.
- R12: Changing `train_i` after the start edge does not change the mode of the pass in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin one pass |
| train_i | input | 1 | 1 selects training mode, sampled at start |
| n_in_i | input | 9 | Number of input words for the pass |
| n_out_i | input | 7 | Number of neuron results for the pass |
| rx_valid_i | input | 1 | Router offers an input word |
| rx_data_i | input | 8 | Input word from the router |
| rx_ready_o | output | 1 | Core is accepting input words |
| drv_addr_i | input | 9 | Input buffer address read by the crossbar drivers |
| drv_word_o | output | 8 | Input buffer word at `drv_addr_i` |
| xbar_eval_o | output | 1 | Crossbar evaluation window |
| adc_sel_o | output | 7 | Neuron whose quantized output is being captured |
| adc_code_i | input | 3 | Quantized output of the selected neuron |
| tx_valid_o | output | 1 | Result word offered to the router |
| tx_data_o | output | 8 | Result word, code in bits [2:0] |
| tx_ready_i | input | 1 | Router accepts the result word |
| bwd_en_o | output | 1 | Back-propagation phase enable |
| upd_en_o | output | 1 | Weight-update phase enable |
| busy_o | output | 1 | A pass is in progress |

## Verification
The bench targets four kinds of mistake.

Dwell off-by-ones are the first. A timer loaded with the dwell itself instead of the dwell minus one would stretch evaluation to 5 or 55 cycles, or back-propagation to 161.

Count boundaries are the second. The bench uses a single-word pass, a single-result pass, and counts of 0 that must become 400 inputs and 100 results. A sequencer that compares against the raw count would hang or exit after one beat.

Router stalls are the third. During stalls the bench checks that a result is neither skipped nor repeated and that `tx_data_o` holds.

The fourth is start and mode requests during a pass. A sequencer that restarts, or that follows a late change of `train_i`, would diverge from the cycle model.

// File: rtl/nc_phase_ctrl.sv
module nc_phase_ctrl #(
  parameter int IN_MAX   = 400,
  parameter int OUT_MAX  = 100,
  parameter int DW       = 8,
  parameter int CODE_W   = 3,
  parameter int EVAL_CYC = 4,
  parameter int FWD_CYC  = 54,
  parameter int BWD_CYC  = 160,
  parameter int UPD_CYC  = 200,
  localparam int INW = $clog2(IN_MAX + 1),
  localparam int ONW = $clog2(OUT_MAX + 1),
  localparam int IAW = $clog2(IN_MAX),
  localparam int OAW = $clog2(OUT_MAX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              train_i,
  input  logic [INW-1:0]    n_in_i,
  input  logic [ONW-1:0]    n_out_i,
  input  logic              rx_valid_i,
  input  logic [DW-1:0]     rx_data_i,
  output logic              rx_ready_o,
  input  logic [IAW-1:0]    drv_addr_i,
  output logic [DW-1:0]     drv_word_o,
  output logic              xbar_eval_o,
  output logic [OAW-1:0]    adc_sel_o,
  input  logic [CODE_W-1:0] adc_code_i,
  output logic              tx_valid_o,
  output logic [DW-1:0]     tx_data_o,
  input  logic              tx_ready_i,
  output logic              bwd_en_o,
  output logic              upd_en_o,
  output logic              busy_o
);
  localparam int CW   = INW > ONW ? INW : ONW;
  localparam int T_A  = EVAL_CYC > FWD_CYC ? EVAL_CYC : FWD_CYC;
  localparam int T_B  = BWD_CYC > UPD_CYC ? BWD_CYC : UPD_CYC;
  localparam int TMAX = T_A > T_B ? T_A : T_B;
  localparam int TW   = $clog2(TMAX);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_EVAL, S_CAP, S_SEND, S_BWD, S_UPD} st_t;

  st_t             st;
  logic            mode_q;
  logic [INW-1:0]  nin_q;
  logic [ONW-1:0]  nout_q;
  logic [CW-1:0]   idx;
  logic [TW-1:0]   tmr;
  logic [DW-1:0]     in_mem  [IN_MAX];
  logic [CODE_W-1:0] out_mem [OUT_MAX];

  wire in_last  = idx == CW'(nin_q) - CW'(1);
  wire out_last = idx == CW'(nout_q) - CW'(1);
  wire tmr_zero = tmr == '0;

  assign busy_o      = st != S_IDLE;
  assign rx_ready_o  = st == S_LOAD;
  assign xbar_eval_o = st == S_EVAL;
  assign tx_valid_o  = st == S_SEND;
  assign bwd_en_o    = st == S_BWD;
  assign upd_en_o    = st == S_UPD;
  assign adc_sel_o   = idx[OAW-1:0];
  assign drv_word_o  = in_mem[drv_addr_i];
  assign tx_data_o   = {{(DW-CODE_W){1'b0}}, out_mem[idx[OAW-1:0]]};

  always_ff @(posedge clk)
    if (st == S_LOAD && rx_valid_i) in_mem[idx[IAW-1:0]] <= rx_data_i;

  always_ff @(posedge clk)
    if (st == S_CAP) out_mem[idx[OAW-1:0]] <= adc_code_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      mode_q <= 1'b0;
      nin_q  <= '0;
      nout_q <= '0;
      idx    <= '0;
      tmr    <= '0;
    end else begin
      case (st)
        S_IDLE: if (start_i) begin
          st     <= S_LOAD;
          mode_q <= train_i;
          nin_q  <= (n_in_i == '0 || n_in_i > INW'(IN_MAX)) ? INW'(IN_MAX) : n_in_i;
          nout_q <= (n_out_i == '0 || n_out_i > ONW'(OUT_MAX)) ? ONW'(OUT_MAX) : n_out_i;
          idx    <= '0;
        end
        S_LOAD: if (rx_valid_i) begin
          if (in_last) begin
            st  <= S_EVAL;
            idx <= '0;
            tmr <= mode_q ? TW'(FWD_CYC - 1) : TW'(EVAL_CYC - 1);
          end else idx <= idx + CW'(1);
        end
        S_EVAL: if (tmr_zero) st <= S_CAP; else tmr <= tmr - TW'(1);
        S_CAP: begin
          if (out_last) begin
            st  <= S_SEND;
            idx <= '0;
          end else idx <= idx + CW'(1);
        end
        S_SEND: if (tx_ready_i) begin
          if (out_last) begin
            st  <= mode_q ? S_BWD : S_IDLE;
            idx <= '0;
            tmr <= TW'(BWD_CYC - 1);
          end else idx <= idx + CW'(1);
        end
        S_BWD: if (tmr_zero) begin
          st  <= S_UPD;
          tmr <= TW'(UPD_CYC - 1);
        end else tmr <= tmr - TW'(1);
        S_UPD: if (tmr_zero) st <= S_IDLE; else tmr <= tmr - TW'(1);
        default: st <= S_IDLE;
      endcase
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !tx_valid_o && !xbar_eval_o && !bwd_en_o && !upd_en_o && !rx_ready_o);

  p_start_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && start_i |=> busy_o && rx_ready_o);

  p_eval_after_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xbar_eval_o) |-> $past(rx_ready_o && rx_valid_i));

  p_tx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

  p_recog_no_train_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !mode_q |-> !bwd_en_o && !upd_en_o);

  p_bwd_then_upd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bwd_en_o) |-> upd_en_o);

  p_upd_then_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(upd_en_o) |-> !busy_o);

  p_one_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_ready_o, xbar_eval_o, tx_valid_o, bwd_en_o, upd_en_o}));
endmodule

// File: tb/nc_phase_ctrl_tb.sv
module nc_phase_ctrl_tb_top;
  logic clk = 0, rst_n = 0;
  logic start_i = 0, train_i = 0, rx_valid_i = 0, tx_ready_i = 1;
  logic [8:0] n_in_i = 0, drv_addr_i = 0;
  logic [6:0] n_out_i = 0;
  logic [7:0] rx_data_i = 0;
  logic [2:0] adc_code_i;
  logic rx_ready_o, xbar_eval_o, tx_valid_o, bwd_en_o, upd_en_o, busy_o;
  logic [7:0] drv_word_o, tx_data_o;
  logic [6:0] adc_sel_o;

  int tests = 0, fails = 0, salt = 0, stall = 0, cyc = 0, beats = 0;
  bit seen_bwd = 0;

  always #4 clk = ~clk;

  assign adc_code_i = 3'(int'(adc_sel_o) * 3 + salt);

  nc_phase_ctrl dut_i (.*);

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference: phase number, counters and queues
  int m_ph = 0, m_tr = 0, m_need = 0, m_nout = 0, m_got = 0, m_left = 0, m_cap = 0;
  byte unsigned in_q[$];
  int out_q[$];

  always @(posedge clk) begin
    cyc++;
    if (rx_valid_i && rx_ready_o) beats++;
    if (!rst_n) m_ph = 0;
    else case (m_ph)
      0: if (start_i) begin
        m_ph = 1; m_tr = int'(train_i); m_got = 0;
        m_need = (n_in_i == 0 || n_in_i > 400) ? 400 : int'(n_in_i);
        m_nout = (n_out_i == 0 || n_out_i > 100) ? 100 : int'(n_out_i);
        in_q.delete(); out_q.delete();
      end
      1: if (rx_valid_i) begin
        in_q.push_back(rx_data_i); m_got++;
        if (m_got == m_need) begin m_ph = 2; m_left = m_tr ? 54 : 4; end
      end
      2: begin m_left--; if (m_left == 0) begin m_ph = 3; m_cap = 0; end end
      3: begin
        out_q.push_back((m_cap * 3 + salt) % 8); m_cap++;
        if (m_cap == m_nout) m_ph = 4;
      end
      4: if (tx_ready_i) begin
        void'(out_q.pop_front());
        if (out_q.size() == 0) begin m_ph = m_tr ? 5 : 0; m_left = 160; end
      end
      5: begin m_left--; if (m_left == 0) begin m_ph = 6; m_left = 200; end end
      6: begin m_left--; if (m_left == 0) m_ph = 0; end
      default: m_ph = 0;
    endcase
  end

  always @(posedge clk) begin
    #2;
    tx_ready_i = stall ? (($random & 3) != 0) : 1'b1;
    drv_addr_i = 9'(cyc % (in_q.size() > 0 ? in_q.size() : 1));
  end

  always @(negedge clk) if (rst_n) begin
    if (bwd_en_o) seen_bwd = 1;
    chk("R11 busy", int'(busy_o), int'(m_ph != 0));
    chk("R3 rx_ready", int'(rx_ready_o), int'(m_ph == 1));
    chk(m_tr ? "R6 eval" : "R5 eval", int'(xbar_eval_o), int'(m_ph == 2));
    chk("R8 tx_valid", int'(tx_valid_o), int'(m_ph == 4));
    chk("R10 bwd", int'(bwd_en_o), int'(m_ph == 5));
    chk("R10 upd", int'(upd_en_o), int'(m_ph == 6));
    if (m_ph == 3) chk("R7 adc_sel", int'(adc_sel_o), m_cap);
    if (m_ph == 4 && out_q.size() > 0) chk("R8 tx_data", int'(tx_data_o), out_q[0]);
    if (int'(drv_addr_i) < in_q.size()) chk("R3 drv_word", int'(drv_word_o), int'(in_q[drv_addr_i]));
  end

  task automatic run(bit tr, int nin, int nout, int words, int gap, bit poke);
    @(posedge clk); #2;
    start_i = 1; train_i = tr; n_in_i = 9'(nin); n_out_i = 7'(nout);
    @(posedge clk); #2;
    start_i = 0;
    @(negedge clk);
    chk("R2 busy after start", int'(busy_o), 1);
    chk("R2 ready after start", int'(rx_ready_o), 1);
    @(posedge clk); #2;
    for (int i = 0; i < words; i++) begin
      rx_valid_i = 1; rx_data_i = 8'($random);
      if (poke && i == 1) begin start_i = 1; train_i = ~tr; end
      @(posedge clk); #2;
      rx_valid_i = 0; start_i = 0;
      for (int g = 0; g < gap; g++) begin @(posedge clk); #2; end
    end
    while (busy_o) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", int'(busy_o), 0);
    chk("R1 tx_valid in reset", int'(tx_valid_o), 0);
    @(posedge clk); #2; rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 idle after reset", int'({busy_o, rx_ready_o, xbar_eval_o, tx_valid_o, bwd_en_o, upd_en_o}), 0);

    salt = 1; seen_bwd = 0;
    run(0, 5, 3, 5, 0, 1);
    chk("R9 no backward in recognition", int'(seen_bwd), 0);
    chk("R9 idle after recognition", int'(busy_o), 0);

    salt = 4; stall = 1;
    run(0, 3, 4, 3, 2, 0);

    salt = 2; seen_bwd = 0;
    run(1, 8, 2, 8, 1, 1);
    chk("R12 training kept after train_i change", int'(seen_bwd), 1);

    salt = 7; stall = 0; beats = 0;
    run(0, 0, 0, 400, 0, 0);
    chk("R4 zero count loads maximum", beats, 400);

    salt = 5; stall = 1; seen_bwd = 0;
    run(1, 1, 1, 1, 0, 0);
    chk("R10 minimal training pass", int'(seen_bwd), 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule